// File: doc/BRIEF.md
# Resumable Serial Register Read Port

This block is the slave side of a serial read interface for a converter's registers. An external host drives the serial clock. The host lowers an active-low frame select and then clocks a 24-bit word out, MSB first. One bit moves on each falling edge of the serial clock. The host may raise frame select partway through a word. The data output is then disabled, and the bit position is kept. When frame select falls again, the transfer resumes at the first unread bit.

An address input chooses the source of a word. It is sampled only when a new word begins. One source is the conversion result register. Its active-low data-ready flag goes low when a fresh result arrives. The flag rises on the exact serial-clock edge that consumes the last bit, not when the frame ends. The other source is the control/calibration word. Such a read always moves exactly 24 bits and never touches data-ready.

All serial inputs are sampled by a faster system clock through synchronisers and edge detectors. The output enable is meant to steer an external tri-state pad. A conversion result that arrives while a result word is only partly read is held back. It is loaded after that word completes, so a word is never corrupted mid-read.

Top module: `sreg_read_port`

## Requirements
- R1: After reset the output enable is low, the serial data output is 0 and data-ready (active low) is high.
- R2: A falling frame select enables the output and presents the first unread bit of the word. At the start of a word this is bit 23, the MSB.
- R3: While the output is enabled, each falling serial-clock edge presents the next lower bit. The k-th falling edge of a word presents bit 23-k.
- R4: The 24th falling serial-clock edge of a word disables the output. For a result-register word it also sets data-ready high.
- R5: A rising frame select in the middle of a word disables the output. The bit position is kept, and the next falling frame select presents that same bit again.
- R6: Data-ready stays low during a result-register read until all 24 bits are read, however many times frame select toggles.
- R7: The address is sampled at the start of a word: 1 selects the result register and 0 the control word. Address changes inside a word are ignored. A control read moves 24 bits and leaves data-ready unchanged. The next read restarts at the MSB.
- R8: A new conversion result that arrives while no result-register word is in progress loads the result register and drives data-ready low.
- R9: A conversion result that arrives during a partly read result-register word does not alter that word. It is loaded, and data-ready goes low, after the word completes.
- R10: Serial-clock edges while frame select is high do not move the bit position.
- R11: The bit counter never reaches the word width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Host serial clock, idles low |
| frame_n_i | input | 1 | Active-low frame select |
| addr_i | input | 1 | Source select: 1 result register, 0 control word |
| conv_valid_i | input | 1 | One-cycle strobe for a new conversion result |
| conv_word_i | input | 24 | New conversion result |
| ctrl_word_i | input | 24 | Current control/calibration word |
| sdata_o | output | 1 | Serial data, 0 while disabled |
| sdata_oe_o | output | 1 | Enable for the tri-state data pad |
| drdy_n_o | output | 1 | Active-low data-ready flag |

## Verification
Some rules hold on every system cycle, and the assertions check them there. The output must be off whenever the synchronised frame select is high. Data-ready may rise only after a completed result-register word, and it may not fall while such a word is open. The bit counter must stay within range, and it may move only on a serial-clock fall or a frame start. Other behaviour shows only across whole transactions, and only the bench scenarios can show it. These are the MSB-first bit order, resumption at the same bit after a pause, address latching at the start of a word, and a delayed result load that appears only in the word read after the interrupted one.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  typedef enum logic {SRC_CTRL = 1'b0, SRC_DATA = 1'b1} src_e;

  // True when the bit index reached is the final one of a word
  function automatic logic word_end(input int unsigned fall_cnt, input int unsigned width);
    return fall_cnt == width - 1;
  endfunction
endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {(STAGES+1){RST_VAL}};
    else        chain <= {chain[STAGES-1:0], async_i};
  end

  assign level_o = chain[STAGES-1];
  assign rise_o  = chain[STAGES-1] & ~chain[STAGES];
  assign fall_o  = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/read_shifter.sv
module read_shifter
  import sreg_pkg::*;
#(
  parameter int WORD_W = 24,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_fall,
  input  logic              frame_rise,
  input  logic              sclk_fall,
  input  logic              addr_i,
  input  logic [WORD_W-1:0] data_word,
  input  logic [WORD_W-1:0] ctrl_word,
  output logic              sdata,
  output logic              oe,
  output logic              busy_data,
  output logic              done_data,
  output logic [CNT_W-1:0]  bit_cnt
);
  logic [WORD_W-1:0] shreg;
  logic              open_q;
  src_e              src_q;
  logic              done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      open_q  <= 1'b0;
      src_q   <= SRC_CTRL;
      done_q  <= 1'b0;
      oe      <= 1'b0;
      bit_cnt <= '0;
    end else begin
      done_q <= 1'b0;
      if (frame_fall) begin
        oe <= 1'b1;
        if (!open_q) begin
          open_q  <= 1'b1;
          src_q   <= addr_i ? SRC_DATA : SRC_CTRL;
          shreg   <= addr_i ? data_word : ctrl_word;
          bit_cnt <= '0;
        end
      end else if (frame_rise) begin
        oe <= 1'b0;
      end else if (sclk_fall && oe) begin
        if (word_end(int'(bit_cnt), WORD_W)) begin
          bit_cnt <= '0;
          open_q  <= 1'b0;
          oe      <= 1'b0;
          done_q  <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          shreg   <= {shreg[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sdata     = oe & shreg[WORD_W-1];
  assign busy_data = open_q & (src_q == SRC_DATA);
  assign done_data = done_q & (src_q == SRC_DATA);
endmodule

// File: rtl/ready_keeper.sv
module ready_keeper #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_valid,
  input  logic [WORD_W-1:0] conv_word,
  input  logic              busy_data,
  input  logic              done_data,
  output logic [WORD_W-1:0] data_word,
  output logic              drdy_n
);
  logic              pend_q;
  logic [WORD_W-1:0] pend_word;
  logic              can_load;

  assign can_load = !busy_data && !done_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_word <= '0;
      pend_word <= '0;
      pend_q    <= 1'b0;
      drdy_n    <= 1'b1;
    end else begin
      if (done_data) drdy_n <= 1'b1;
      if (conv_valid || pend_q) begin
        if (can_load) begin
          data_word <= conv_valid ? conv_word : pend_word;
          pend_q    <= 1'b0;
          drdy_n    <= 1'b0;
        end else if (conv_valid) begin
          pend_word <= conv_word;
          pend_q    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sreg_read_port.sv
module sreg_read_port #(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              frame_n_i,
  input  logic              addr_i,
  input  logic              conv_valid_i,
  input  logic [WORD_W-1:0] conv_word_i,
  input  logic [WORD_W-1:0] ctrl_word_i,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic              drdy_n_o
);
  localparam int CNT_W = $clog2(WORD_W);

  logic sclk_lvl, sclk_rise, sclk_fall;
  logic frame_lvl, frame_rise, frame_fall;
  logic busy_data, done_data;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] data_word;

  sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .async_i(sclk_i),
    .level_o(sclk_lvl), .rise_o(sclk_rise), .fall_o(sclk_fall)
  );

  sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_frame_sync (
    .clk(clk), .rst_n(rst_n), .async_i(frame_n_i),
    .level_o(frame_lvl), .rise_o(frame_rise), .fall_o(frame_fall)
  );

  read_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .frame_fall(frame_fall), .frame_rise(frame_rise), .sclk_fall(sclk_fall),
    .addr_i(addr_i), .data_word(data_word), .ctrl_word(ctrl_word_i),
    .sdata(sdata_o), .oe(sdata_oe_o),
    .busy_data(busy_data), .done_data(done_data), .bit_cnt(bit_cnt)
  );

  ready_keeper #(.WORD_W(WORD_W)) u_ready (
    .clk(clk), .rst_n(rst_n),
    .conv_valid(conv_valid_i), .conv_word(conv_word_i),
    .busy_data(busy_data), .done_data(done_data),
    .data_word(data_word), .drdy_n(drdy_n_o)
  );
endmodule

// File: rtl/sreg_read_port_chk.sv
module sreg_read_port_chk #(
  parameter int CNT_W  = 5,
  parameter int WORD_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk_lvl,
  input logic             sclk_rise,
  input logic             sclk_fall,
  input logic             frame_lvl,
  input logic             frame_fall,
  input logic             busy_data,
  input logic             done_data,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             sdata_oe_o,
  input logic             drdy_n_o
);
  // Frame select high keeps the pad released
  assert_oe_off_frame_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_lvl |=> !sdata_oe_o);

  // Data-ready rises only when a result word has just completed
  assert_rdy_rise_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_n_o) |-> $past(done_data));

  // No result load while a result word is open
  assert_rdy_hold_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_data |=> !$fell(drdy_n_o));

  // Counter within the word
  assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bit_cnt) < WORD_W);

  // Position moves only on a serial-clock fall or at a frame start
  assert_cnt_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_fall && !frame_fall) |=> $stable(bit_cnt));

  // A rising serial-clock edge never moves the position
  assert_rise_no_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !frame_fall) |=> $stable(bit_cnt));

  // Frame starts only with the serial clock idle low
  assert_frame_start_sclk_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_fall |-> !sclk_lvl);
endmodule

bind sreg_read_port sreg_read_port_chk #(.CNT_W($clog2(WORD_W)), .WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .sclk_lvl(sclk_lvl), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
  .frame_lvl(frame_lvl), .frame_fall(frame_fall),
  .busy_data(busy_data), .done_data(done_data), .bit_cnt(bit_cnt),
  .sdata_oe_o(sdata_oe_o), .drdy_n_o(drdy_n_o)
);

// File: tb/sreg_read_port_tb_top.sv
`timescale 1ns/1ps
module sreg_read_port_tb_top;
  localparam int W    = 24;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic frame_n = 1'b1;
  logic addr = 1'b1;
  logic conv_valid = 1'b0;
  logic [W-1:0] conv_word = '0;
  logic [W-1:0] ctrl_word = '0;
  logic sdata, oe, drdy_n;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sreg_read_port dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .frame_n_i(frame_n), .addr_i(addr),
    .conv_valid_i(conv_valid), .conv_word_i(conv_word), .ctrl_word_i(ctrl_word),
    .sdata_o(sdata), .sdata_oe_o(oe), .drdy_n_o(drdy_n)
  );

  function automatic logic exp_bit(input logic [W-1:0] w, input int k);
    return w[W-1-k];
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sck();
    sclk = 1'b1; tick(HALF);
    sclk = 1'b0; tick(HALF);
  endtask

  task automatic frame(input logic lvl);
    frame_n = lvl; tick(HALF);
  endtask

  task automatic push_conv(input logic [W-1:0] w);
    @(negedge clk); conv_valid = 1'b1; conv_word = w;
    @(negedge clk); conv_valid = 1'b0;
    tick(3);
  endtask

  // Read one word; split pauses at random; optional conversion injection at fall inj_at
  task automatic read_word(input logic [W-1:0] w, input bit a, input bit split,
                           input bit rdy_low, input int inj_at, input logic [W-1:0] inj_w);
    addr = a;
    frame(1'b0);
    addr = ~a; // R7: later address changes must not matter
    chk(oe == 1'b1, "R2 oe on frame start", oe, 1);
    chk(sdata == exp_bit(w, 0), "R2 MSB first", sdata, exp_bit(w, 0));
    for (int k = 1; k <= W; k++) begin
      sck();
      if (k == inj_at) begin
        push_conv(inj_w);
        if (a) chk(drdy_n == 1'b0 || !rdy_low, "R9 held mid-word", drdy_n, 0);
        else   chk(drdy_n == 1'b0, "R8 load during control read", drdy_n, 0);
      end
      if (k < W) begin
        chk(sdata == exp_bit(w, k), "R3 bit order", sdata, exp_bit(w, k));
        if (a && rdy_low) chk(drdy_n == 1'b0, "R6 ready held low", drdy_n, 0);
        if (split && ($urandom % 5 == 0)) begin
          frame(1'b1);
          chk(oe == 1'b0, "R5 pause releases output", oe, 0);
          if (a && rdy_low) chk(drdy_n == 1'b0, "R6 low during pause", drdy_n, 0);
          sck(); sck();
          frame(1'b0);
          chk(oe == 1'b1 && sdata == exp_bit(w, k), "R10 resume same bit", sdata, exp_bit(w, k));
        end
      end
    end
    chk(oe == 1'b0, "R4 output off after last edge", oe, 0);
    frame(1'b1);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a_w, b_w, c_w, d_w, k_w;
    void'($urandom(32'd4242));
    tick(4);
    chk(oe == 1'b0 && sdata == 1'b0, "R1 output idle at reset", {oe, sdata}, 0);
    chk(drdy_n == 1'b1, "R1 ready high at reset", drdy_n, 1);
    rst_n = 1'b1;
    tick(4);
    chk(drdy_n == 1'b1, "R1 ready high after reset", drdy_n, 1);

    // R8: fresh result with nothing open
    a_w = 24'hA5C3_0F;
    push_conv(a_w);
    chk(drdy_n == 1'b0, "R8 ready low on new result", drdy_n, 0);

    // R3/R4 whole-word read without pauses
    read_word(a_w, 1'b1, 1'b0, 1'b1, 0, '0);
    chk(drdy_n == 1'b1, "R4 ready high after result word", drdy_n, 1);

    // R5/R6/R9/R10: split read with a result arriving mid-word
    b_w = 24'h3C_96E1;
    c_w = 24'hF0_0F55;
    push_conv(b_w);
    addr = 1'b1;
    frame(1'b0);
    for (int k = 1; k <= 10; k++) sck();
    chk(sdata == exp_bit(b_w, 10), "R3 tenth bit", sdata, exp_bit(b_w, 10));
    frame(1'b1);
    chk(oe == 1'b0 && sdata == 1'b0, "R5 pause releases output", oe, 0);
    sck(); sck(); sck();
    push_conv(c_w);
    chk(drdy_n == 1'b0, "R9 ready stays low while held", drdy_n, 0);
    frame(1'b0);
    chk(sdata == exp_bit(b_w, 10), "R10 no shift while paused", sdata, exp_bit(b_w, 10));
    for (int k = 11; k <= W; k++) begin
      sck();
      if (k < W) chk(sdata == exp_bit(b_w, k), "R9 old word intact", sdata, exp_bit(b_w, k));
    end
    chk(oe == 1'b0, "R4 output off at word end", oe, 0);
    frame(1'b1);
    chk(drdy_n == 1'b0, "R9 held result loaded after word", drdy_n, 0);
    read_word(c_w, 1'b1, 1'b1, 1'b1, 0, '0);
    chk(drdy_n == 1'b1, "R9 ready high after held word read", drdy_n, 1);

    // R7: control reads leave ready alone and restart at MSB
    k_w = 24'h81_2C7E;
    ctrl_word = k_w;
    read_word(k_w, 1'b0, 1'b1, 1'b0, 0, '0);
    chk(drdy_n == 1'b1, "R7 control read keeps ready", drdy_n, 1);
    d_w = 24'h5A_A5C3;
    read_word(k_w, 1'b0, 1'b0, 1'b0, 7, d_w);
    chk(drdy_n == 1'b0, "R7 control completion leaves ready low", drdy_n, 0);
    read_word(d_w, 1'b1, 1'b1, 1'b1, 0, '0);
    chk(drdy_n == 1'b1, "R7 result read after control read", drdy_n, 1);

    // Random results, random pauses, random mid-word arrivals
    for (int it = 0; it < 12; it++) begin
      logic [W-1:0] r_w, n_w;
      int inj;
      r_w = W'($urandom);
      n_w = W'($urandom);
      inj = (it % 2 == 0) ? int'($urandom % 22) + 1 : 0;
      push_conv(r_w);
      chk(drdy_n == 1'b0, "R8 random result ready", drdy_n, 0);
      read_word(r_w, 1'b1, 1'b1, 1'b1, inj, n_w);
      if (inj != 0) begin
        chk(drdy_n == 1'b0, "R9 random held result", drdy_n, 0);
        read_word(n_w, 1'b1, 1'b1, 1'b1, 0, '0);
      end
      chk(drdy_n == 1'b1, "R4 random word end", drdy_n, 1);
      if (it % 3 == 0) begin
        ctrl_word = W'($urandom);
        read_word(ctrl_word, 1'b0, 1'b1, 1'b0, 0, '0);
        chk(drdy_n == 1'b1, "R7 random control read", drdy_n, 1);
      end
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule